// File: doc/BRIEF.md
# Local-Bus Cycle Steering Controller

This block sits on the host side of a processor bus and decides which agent finishes each bus cycle. It watches the processor's cycle-start pulse, latches the address and command, and then hands the cycle to one of three owners. Those owners are the on-board cache/DRAM controller, a local-bus target that claims the cycle on a shared active-low claim line, or the ISA bridge, which takes every cycle that nobody else accepts.

Two static configuration bits tune the timing for slow boards or slow cards. The first, cycle-start delay, pushes the strobe seen by every consumer one clock later, and that includes the cache controller. The second, late claim sampling, moves the decision point from the end of the first T2 to the end of the second T2. A watchdog flags a claimed cycle whose target never answers.

For cycles it owns, the controller returns processor ready. For a claimed cycle it never drives ready, because the local target terminates that cycle itself.

Top module: `lbus_cycle_steer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `bus_strobe`, `isa_start`, `cpu_rdy`, `route_local` and `wdog_err` are all 0.
- R2: With the start delay off, a `cpu_start` sampled at clock edge E0 produces `bus_strobe` high in the single cycle following E0, and `bus_addr` then carries the address present at E0. A memory-hit cycle with `mem_rdy` high returns `cpu_rdy` in cycle 4, counting the cycle after E0 as cycle 1.
- R3: With the start delay on, `bus_strobe`, `isa_start`, `route_local` and `cpu_rdy` each appear exactly one clock later than with the delay off.
- R4: A `mem_hit` seen at the sample point wins over any claim. Such a cycle goes to memory, and its ready timing is the same with early or late sampling.
- R5: With early sampling, the claim is sampled at the end of the first T2 (cycle 2). The route shows in cycle 3 as `route_local` or as an `isa_start` pulse.
- R6: With late sampling, the claim is sampled at the end of the second T2 (cycle 3), and the route shows in cycle 4.
- R7: A claimed cycle never raises `cpu_rdy`. It ends when `local_rdy` is sampled high, after which the controller accepts new cycles.
- R8: An unclaimed, non-hit cycle raises `isa_start` for exactly one cycle. It then returns `cpu_rdy` in the cycle after `isa_rdy` is sampled.
- R9: Slot claims are active low: the cycle counts as claimed when any bit of `slot_claim_n` is 0.
- R10: Both configuration bits are captured only between cycles. Changing them after a cycle has started has no effect on that cycle.
- R11: `wdog_err` rises `wd_limit` clocks after a claimed cycle enters its wait for local ready, provided `local_rdy` has not arrived. It clears once that cycle ends (`wd_limit` ≥ 1).
- R12: At most one of `bus_strobe`, `isa_start` and `cpu_rdy` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_delay | input | 1 | 1 = delay the cycle-start strobe by one clock |
| cfg_late_sample | input | 1 | 1 = sample the claim at the end of the second T2 |
| wd_limit | input | WD_W | Clocks a claimed cycle may wait before `wdog_err` |
| cpu_start | input | 1 | Processor cycle-start pulse (active high) |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_cmd | input | CMD_W | Processor cycle definition |
| mem_hit | input | 1 | On-board cache or DRAM hit |
| slot_claim_n | input | N_SLOTS | Per-slot active-low claims |
| mem_rdy | input | 1 | Memory controller done |
| isa_rdy | input | 1 | ISA bridge done |
| local_rdy | input | 1 | Local-bus target ready |
| bus_strobe | output | 1 | Cycle-start strobe for all consumers |
| bus_addr | output | ADDR_W | Latched address |
| bus_cmd | output | CMD_W | Latched command |
| isa_start | output | 1 | One-cycle start pulse to the ISA bridge |
| route_local | output | 1 | High while a claimed cycle waits for local ready |
| cpu_rdy | output | 1 | Processor ready for host-owned cycles |
| wdog_err | output | 1 | Claimed cycle exceeded `wd_limit` clocks |

## Verification
The bench builds the block with three claim slots, a 16-bit address and an 8-bit watchdog limit set to 5. With three slots, a claim can come from a middle slot, an end slot or all slots at once. A limit of 5 puts watchdog expiry and its clearing inside a dozen clocks. The vector table crosses the two configuration bits with hit, claim and no-claim cycles, so that every route is timed in all four delay/sample combinations. Directed runs cover a configuration change in the middle of a cycle and a local target that stays silent.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2_FIRST,
    ST_T2_WAIT,
    ST_ISA_FWD,
    ST_DONE
  } lbs_state_e;

  typedef enum logic [1:0] {
    OWN_NONE,
    OWN_MEM,
    OWN_LOCAL,
    OWN_ISA
  } lbs_owner_e;
endpackage

// File: rtl/lbs_claim_merge.sv
module lbs_claim_merge #(
  parameter int N_SLOTS = 4
) (
  input  logic [N_SLOTS-1:0] claim_n,
  output logic               claimed
);
  logic [N_SLOTS:0] any_low;

  assign any_low[0] = 1'b0;
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign any_low[g+1] = any_low[g] | ~claim_n[g];
  end
  assign claimed = any_low[N_SLOTS];
endmodule

// File: rtl/lbs_start_stage.sv
module lbs_start_stage (
  input  logic clk,
  input  logic rst,
  input  logic delay_en,
  input  logic start_in,
  output logic start_eff,
  output logic pending
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= start_in;
  end

  assign start_eff = delay_en ? start_q : start_in;
  assign pending   = delay_en & start_q;
endmodule

// File: rtl/lbs_wdog.sv
module lbs_wdog #(
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [WD_W-1:0] limit,
  output logic            expired
);
  logic [WD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      cnt     <= cnt + WD_W'(1);
      expired <= expired | ((cnt + WD_W'(1)) == limit);
    end
  end

  // R11
  expire_run_chk: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(run));
endmodule

// File: rtl/lbus_cycle_steer.sv
module lbus_cycle_steer
  import lbs_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int ADDR_W  = 32,
  parameter int CMD_W   = 3,
  parameter int WD_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start_delay,
  input  logic              cfg_late_sample,
  input  logic [WD_W-1:0]   wd_limit,
  input  logic              cpu_start,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CMD_W-1:0]  cpu_cmd,
  input  logic              mem_hit,
  input  logic [N_SLOTS-1:0] slot_claim_n,
  input  logic              mem_rdy,
  input  logic              isa_rdy,
  input  logic              local_rdy,
  output logic              bus_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CMD_W-1:0]  bus_cmd,
  output logic              isa_start,
  output logic              route_local,
  output logic              cpu_rdy,
  output logic              wdog_err
);
  lbs_state_e state;
  lbs_owner_e owner;
  logic cfg_delay_q, cfg_late_q;
  logic start_eff, pending, claimed, sample_now, cfg_open;

  lbs_claim_merge #(.N_SLOTS(N_SLOTS)) claim_i (
    .claim_n (slot_claim_n),
    .claimed (claimed)
  );

  lbs_start_stage start_i (
    .clk       (clk),
    .rst       (rst),
    .delay_en  (cfg_delay_q),
    .start_in  (cpu_start),
    .start_eff (start_eff),
    .pending   (pending)
  );

  lbs_wdog #(.WD_W(WD_W)) wdog_i (
    .clk     (clk),
    .rst     (rst),
    .run     (route_local),
    .limit   (wd_limit),
    .expired (wdog_err)
  );

  assign cfg_open    = (state == ST_IDLE) && !pending;
  assign route_local = (state == ST_T2_WAIT) && (owner == OWN_LOCAL);
  assign sample_now  = ((state == ST_T2_FIRST) && !cfg_late_q) ||
                       ((state == ST_T2_WAIT) && (owner == OWN_NONE));

  // configuration and address capture between cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_delay_q <= 1'b0;
      cfg_late_q  <= 1'b0;
      bus_addr    <= '0;
      bus_cmd     <= '0;
    end else if (cfg_open) begin
      cfg_delay_q <= cfg_start_delay;
      cfg_late_q  <= cfg_late_sample;
      if (cpu_start) begin
        bus_addr <= cpu_addr;
        bus_cmd  <= cpu_cmd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      owner      <= OWN_NONE;
      bus_strobe <= 1'b0;
      isa_start  <= 1'b0;
      cpu_rdy    <= 1'b0;
    end else begin
      bus_strobe <= 1'b0;
      isa_start  <= 1'b0;
      cpu_rdy    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_eff) begin
            state      <= ST_T1;
            owner      <= OWN_NONE;
            bus_strobe <= 1'b1;
          end
        end
        ST_T1: state <= ST_T2_FIRST;
        ST_T2_FIRST, ST_T2_WAIT: begin
          if (owner == OWN_NONE) begin
            if (mem_hit) begin
              owner <= OWN_MEM;
              state <= ST_T2_WAIT;
            end else if (sample_now) begin
              if (claimed) begin
                owner <= OWN_LOCAL;
                state <= ST_T2_WAIT;
              end else begin
                owner     <= OWN_ISA;
                state     <= ST_ISA_FWD;
                isa_start <= 1'b1;
              end
            end else begin
              state <= ST_T2_WAIT;
            end
          end else if (owner == OWN_MEM) begin
            if (mem_rdy) begin
              cpu_rdy <= 1'b1;
              state   <= ST_DONE;
            end
          end else if (owner == OWN_LOCAL) begin
            if (local_rdy) state <= ST_DONE;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_ISA_FWD: begin
          if (isa_rdy) begin
            cpu_rdy <= 1'b1;
            state   <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  local_no_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && owner == OWN_LOCAL) |-> !cpu_rdy);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_strobe, isa_start, cpu_rdy}));

  // R5
  strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
    bus_strobe |=> (state == ST_T2_FIRST));

  // R8
  isa_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(isa_start) |-> !$past(mem_hit));

  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |->
      ($stable(cfg_late_q) && $stable(cfg_delay_q)));
endmodule

// File: tb/lbus_cycle_steer_tb_top.sv
`timescale 1ns/1ps
module lbus_cycle_steer_tb_top;
  localparam int NS = 3;
  localparam int AW = 16;
  localparam int CW = 3;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst;
  logic cfg_start_delay, cfg_late_sample;
  logic [WW-1:0] wd_limit;
  logic cpu_start;
  logic [AW-1:0] cpu_addr;
  logic [CW-1:0] cpu_cmd;
  logic mem_hit, mem_rdy, isa_rdy, local_rdy;
  logic [NS-1:0] slot_claim_n;
  logic bus_strobe, isa_start, route_local, cpu_rdy, wdog_err;
  logic [AW-1:0] bus_addr;
  logic [CW-1:0] bus_cmd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lbus_cycle_steer #(.N_SLOTS(NS), .ADDR_W(AW), .CMD_W(CW), .WD_W(WW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_start_delay(cfg_start_delay), .cfg_late_sample(cfg_late_sample),
    .wd_limit(wd_limit), .cpu_start(cpu_start), .cpu_addr(cpu_addr),
    .cpu_cmd(cpu_cmd), .mem_hit(mem_hit), .slot_claim_n(slot_claim_n),
    .mem_rdy(mem_rdy), .isa_rdy(isa_rdy), .local_rdy(local_rdy),
    .bus_strobe(bus_strobe), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
    .isa_start(isa_start), .route_local(route_local), .cpu_rdy(cpu_rdy),
    .wdog_err(wdog_err)
  );

  // {delay, late, hit, claim_n[2:0], exp rdy cycle, exp isa cycle, exp local cycle}; 0 = never
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b1, 3'b111, 4'd4, 4'd0, 4'd0},
    {1'b1, 1'b0, 1'b1, 3'b111, 4'd5, 4'd0, 4'd0},
    {1'b0, 1'b1, 1'b1, 3'b110, 4'd4, 4'd0, 4'd0},
    {1'b0, 1'b0, 1'b0, 3'b011, 4'd0, 4'd0, 4'd3},
    {1'b0, 1'b1, 1'b0, 3'b101, 4'd0, 4'd0, 4'd4},
    {1'b0, 1'b0, 1'b0, 3'b111, 4'd4, 4'd3, 4'd0},
    {1'b0, 1'b1, 1'b0, 3'b111, 4'd5, 4'd4, 4'd0},
    {1'b1, 1'b1, 1'b0, 3'b111, 4'd6, 4'd5, 4'd0},
    {1'b1, 1'b0, 1'b0, 3'b110, 4'd0, 4'd0, 4'd4},
    {1'b1, 1'b1, 1'b1, 3'b000, 4'd5, 4'd0, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_start = 1'b0; mem_hit = 1'b0; mem_rdy = 1'b0; isa_rdy = 1'b0;
    local_rdy = 1'b0; slot_claim_n = '1;
  endtask

  // one cycle; returns the first cycle (1 = after the start edge) each output is seen
  task automatic run_cycle(input logic d, input logic l, input logic h,
                           input logic [2:0] cn, input bit flip,
                           input logic [AW-1:0] addr,
                           output int s_c, output int r_c, output int i_c,
                           output int lo_c, output logic [AW-1:0] a_seen);
    cfg_start_delay = d; cfg_late_sample = l;
    repeat (2) @(negedge clk);
    mem_hit = h; slot_claim_n = cn; mem_rdy = 1'b1; isa_rdy = 1'b1;
    local_rdy = 1'b1; cpu_start = 1'b1; cpu_addr = addr; cpu_cmd = 3'd5;
    s_c = 0; r_c = 0; i_c = 0; lo_c = 0; a_seen = '0;
    @(posedge clk);
    @(negedge clk);
    cpu_start = 1'b0;
    if (flip) begin
      cfg_start_delay = ~d; cfg_late_sample = ~l;
    end
    for (int k = 1; k <= 12; k++) begin
      if (k > 1) @(negedge clk);
      if (bus_strobe && s_c == 0) begin s_c = k; a_seen = bus_addr; end
      if (cpu_rdy && r_c == 0) r_c = k;
      if (isa_start && i_c == 0) i_c = k;
      if (route_local && lo_c == 0) lo_c = k;
    end
    idle_inputs();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int s_c, r_c, i_c, lo_c, n_rdy;
    logic [AW-1:0] a_seen;
    rst = 1'b1; cfg_start_delay = 1'b0; cfg_late_sample = 1'b0;
    wd_limit = 8'd5; cpu_addr = '0; cpu_cmd = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_strobe, "R1 bus_strobe", int'(bus_strobe), 0);
    chk(!isa_start, "R1 isa_start", int'(isa_start), 0);
    chk(!cpu_rdy, "R1 cpu_rdy", int'(cpu_rdy), 0);
    chk(!route_local, "R1 route_local", int'(route_local), 0);
    chk(!wdog_err, "R1 wdog_err", int'(wdog_err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_strobe && !cpu_rdy, "R1 after release", int'(bus_strobe), 0);

    // table: R2 R3 R4 R5 R6 R7 R8 R9 timing
    for (int v = 0; v < 10; v++) begin
      logic [17:0] e;
      e = VEC[v];
      run_cycle(e[17], e[16], e[15], e[14:12], 1'b0, AW'(16'hA000 + v),
                s_c, r_c, i_c, lo_c, a_seen);
      chk(s_c == 1 + int'(e[17]), "R2/R3 strobe cycle", s_c, 1 + int'(e[17]));
      chk(a_seen == AW'(16'hA000 + v), "R2 latched address", int'(a_seen), 16'hA000 + v);
      chk(r_c == int'(e[11:8]), "R4/R7/R8 ready cycle", r_c, int'(e[11:8]));
      chk(i_c == int'(e[7:4]), "R5/R6/R8 isa cycle", i_c, int'(e[7:4]));
      chk(lo_c == int'(e[3:0]), "R5/R6/R9 local cycle", lo_c, int'(e[3:0]));
    end

    // R10: configuration flipped after the cycle started
    run_cycle(1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 16'h1234, s_c, r_c, i_c, lo_c, a_seen);
    chk(s_c == 1, "R10 strobe keeps no-delay", s_c, 1);
    chk(i_c == 4, "R10 isa keeps late sample", i_c, 4);
    chk(r_c == 5, "R10 ready timing", r_c, 5);

    // R11 / R7: claimed cycle with silent target
    cfg_start_delay = 1'b0; cfg_late_sample = 1'b0;
    repeat (2) @(negedge clk);
    slot_claim_n = 3'b011; cpu_start = 1'b1; cpu_addr = 16'h0042;
    n_rdy = 0;
    @(posedge clk);
    @(negedge clk);
    cpu_start = 1'b0;
    for (int k = 1; k <= 13; k++) begin
      if (k > 1) @(negedge clk);
      if (cpu_rdy) n_rdy++;
      if (k == 7) chk(!wdog_err, "R11 not yet expired", int'(wdog_err), 0);
      if (k == 8) chk(wdog_err, "R11 expired", int'(wdog_err), 1);
      if (k == 9) local_rdy = 1'b1;
      if (k == 10) local_rdy = 1'b0;
      if (k == 12) chk(!wdog_err, "R11 cleared after end", int'(wdog_err), 0);
    end
    chk(n_rdy == 0, "R7 no host ready on claimed", n_rdy, 0);
    idle_inputs();
    repeat (2) @(negedge clk);
    // R7: controller free again
    run_cycle(1'b0, 1'b0, 1'b1, 3'b111, 1'b0, 16'h0777, s_c, r_c, i_c, lo_c, a_seen);
    chk(r_c == 4, "R7 next cycle served", r_c, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule